// File: doc/BRIEF.md
# Triangle-Against-Triangle Givens Elimination Array

This block clears a 4x4 upper-triangular patch that sits in a lower group of rows. It does so by rotating each of those rows against a group of pivot rows that are already upper-triangular. Each plane rotation is done by a pipelined CORDIC rotor. The rotor settles its angle while the first non-zero pair in the pivot's diagonal column passes through (vectoring). It then applies the same angle to every later column of that pair. Both the pivot row and the target row of a pair come out modified.

Rows enter as streams: one column per clock, all rows of both groups in parallel, with a start pulse alongside column 0. Extra columns, such as an appended identity that gathers the accumulated orthogonal factor, simply trail the matrix columns. A larger decomposition can run this array beside a four-row triangularizer, one block of rows at a time.

Inside, the rotors are laid out on a diagonal wavefront. At level `l`, pivot row `i` meets target row `i-l`, with the angle taken from column `i`. There are four levels, ten rotors in total, and matched delay lines for the rows that sit idle at a level.

Top module: `tri_elim_array`

## Requirements
- R1: After reset, `start_o` is low and every element of `piv_o` and `tgt_o` is zero until a frame has crossed the array.
- R2: The elements of a frame are two's complement fixed-point values. Column `c` of every row is presented `c` cycles after the cycle in which `start_i` is high. `start_o` rises exactly BLOCK*(STAGES+2) cycles after `start_i`, and output column `c` appears `c` cycles after `start_o`.
- R3: In output columns 0..BLOCK-1, every entry of the target rows lies within 0.02 (scale 2^12 = 1.0) of zero.
- R4: In output columns 0..BLOCK-1, pivot row `i` keeps its zeros in columns below `i`, within the same tolerance.
- R5: The transform applied to the 2*BLOCK rows is orthogonal, with the CORDIC gain removed. With an identity appended after the matrix columns, the output rows of that appended part are orthonormal within 0.02.
- R6: One transform is applied to every column of a frame. Output columns 0..BLOCK-1 equal the appended part times the input matrix, within 0.02.
- R7: Pivot diagonals of either sign, or zero, are handled. Each output pivot diagonal entry is non-negative (not below -0.02).
- R8: Frames may follow one another with no idle cycle between them, once each frame's row length has elapsed. Every frame is transformed independently of its neighbours.
- R9: A frame whose target rows are all zero and whose pivot diagonals are positive leaves every row as it was, within 0.02.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | High alongside column 0 of a frame |
| piv_i | input | BLOCK*DATA_W | Current column of the pivot rows, row r in slice r |
| tgt_i | input | BLOCK*DATA_W | Current column of the target rows, row r in slice r |
| start_o | output | 1 | High alongside column 0 of a processed frame |
| piv_o | output | BLOCK*DATA_W | Current column of the updated pivot rows |
| tgt_o | output | BLOCK*DATA_W | Current column of the updated target rows |

## Verification
The hardest case to reach is a new frame's token re-latching a rotor's stage directions while the trailing appended columns of the previous frame are still inside later stages of the same rotor. A single isolated frame never exercises that overlap. The stimulus therefore sends four frames with no gap between them, then four more with gaps. Each frame is checked for zeroed targets, orthonormality and consistency. The frames deliberately include negative and zero pivot diagonals, to drive the half-plane flip, and an all-zero target group, to drive near-identity angles.

// File: rtl/tri_elim_pkg.sv
package tri_elim_pkg;

   // rotation sense chosen by one micro-rotation stage
   typedef enum logic {
      ROT_CCW = 1'b0,
      ROT_CW  = 1'b1
   } rot_dir_e;

   // cycles through one rotor: half-plane stage, micro stages, gain stage
   function automatic int unit_latency(input int stages);
      return stages + 2;
   endfunction

   // token tap for the rotor at a wavefront level that uses a pivot row
   function automatic int level_tap(input int level, input int pivot, input int lat);
      return level * lat + pivot;
   endfunction

   // number of entries cleared in a triangular patch
   function automatic int patch_count(input int blk);
      return blk * (blk + 1) / 2;
   endfunction

endpackage

// File: rtl/tri_elim_delay.sv
module tri_elim_delay #(
   parameter int W     = 16,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] d_o
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("tri_elim_delay: DEPTH must be at least 1");
   end
   if (W < 1) begin : g_bad_width
      $error("tri_elim_delay: W must be at least 1");
   end

   logic [W-1:0] sr_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) sr_q[k] <= '0;
      end else begin
         sr_q[0] <= d_i;
         for (int k = 1; k < DEPTH; k++) sr_q[k] <= sr_q[k-1];
      end
   end

   assign d_o = sr_q[DEPTH-1];

endmodule

// File: rtl/tri_elim_micro.sv
module tri_elim_micro
   import tri_elim_pkg::*;
#(
   parameter int IW    = 18,
   parameter int SHIFT = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tok_i,
   input  logic signed [IW-1:0] x_i,
   input  logic signed [IW-1:0] y_i,
   output logic                 tok_o,
   output logic signed [IW-1:0] x_o,
   output logic signed [IW-1:0] y_o
);

   if (SHIFT < 0 || SHIFT >= IW) begin : g_bad_shift
      $error("tri_elim_micro: SHIFT out of range");
   end

   rot_dir_e             dir_q;
   rot_dir_e             dir_use;
   logic signed [IW-1:0] xs;
   logic signed [IW-1:0] ys;

   // the token picks a fresh direction; other samples reuse the held one
   always_comb begin
      dir_use = dir_q;
      if (tok_i) dir_use = y_i[IW-1] ? ROT_CCW : ROT_CW;
      xs = x_i >>> SHIFT;
      ys = y_i >>> SHIFT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= ROT_CW;
         tok_o <= 1'b0;
         x_o   <= '0;
         y_o   <= '0;
      end else begin
         tok_o <= tok_i;
         if (tok_i) dir_q <= dir_use;
         if (dir_use == ROT_CW) begin
            x_o <= x_i + ys;
            y_o <= y_i - xs;
         end else begin
            x_o <= x_i - ys;
            y_o <= y_i + xs;
         end
      end
   end

   // R3
   xgrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tok_i |=> (x_o >= $past(x_i)));

endmodule

// File: rtl/tri_elim_rotor.sv
module tri_elim_rotor
   import tri_elim_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int STAGES    = 14,
   parameter int GAIN_FRAC = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tok_i,
   input  logic signed [DATA_W-1:0] x_i,
   input  logic signed [DATA_W-1:0] y_i,
   output logic signed [DATA_W-1:0] x_o,
   output logic signed [DATA_W-1:0] y_o
);

   localparam int IW     = DATA_W + 2;
   localparam int PW     = IW + GAIN_FRAC + 2;
   localparam int KINV_I = $rtoi(0.6072529350088813 * (1 << GAIN_FRAC) + 0.5);
   localparam logic signed [PW-1:0] KIN = PW'(KINV_I);
   localparam logic signed [PW-1:0] RND = PW'(1) <<< (GAIN_FRAC - 1);

   if (STAGES < 10 || STAGES > DATA_W) begin : g_bad_stages
      $error("tri_elim_rotor: STAGES must lie in 10..DATA_W");
   end
   if (GAIN_FRAC < 8 || GAIN_FRAC > 28) begin : g_bad_gain
      $error("tri_elim_rotor: GAIN_FRAC must lie in 8..28");
   end

   // half-plane stage: a token with negative x flips the pair by 180 degrees
   logic                 flip_q;
   logic                 flip_use;
   logic                 tok_p;
   logic signed [IW-1:0] xe;
   logic signed [IW-1:0] ye;
   logic signed [IW-1:0] xp;
   logic signed [IW-1:0] yp;

   always_comb begin
      xe       = IW'(x_i);
      ye       = IW'(y_i);
      flip_use = tok_i ? xe[IW-1] : flip_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flip_q <= 1'b0;
         tok_p  <= 1'b0;
         xp     <= '0;
         yp     <= '0;
      end else begin
         tok_p <= tok_i;
         if (tok_i) flip_q <= flip_use;
         xp <= flip_use ? -xe : xe;
         yp <= flip_use ? -ye : ye;
      end
   end

   // R7
   preflip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tok_p |-> !xp[IW-1]);

   // micro-rotation chain
   logic signed [IW-1:0] xc [STAGES+1];
   logic signed [IW-1:0] yc [STAGES+1];
   logic                 tc [STAGES+1];

   assign xc[0] = xp;
   assign yc[0] = yp;
   assign tc[0] = tok_p;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      tri_elim_micro #(
         .IW   (IW),
         .SHIFT(s)
      ) u_micro (
         .clk  (clk),
         .rst_n(rst_n),
         .tok_i(tc[s]),
         .x_i  (xc[s]),
         .y_i  (yc[s]),
         .tok_o(tc[s+1]),
         .x_o  (xc[s+1]),
         .y_o  (yc[s+1])
      );
   end

   logic signed [IW-1:0] mag_xe;
   logic signed [IW-1:0] mag_ye;

   always_comb begin
      mag_xe = xc[STAGES][IW-1] ? -xc[STAGES] : xc[STAGES];
      mag_ye = yc[STAGES][IW-1] ? -yc[STAGES] : yc[STAGES];
   end

   // R3
   yres_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tc[STAGES] |-> (mag_ye <= (mag_xe >>> (STAGES - 3)) + IW'(4 * STAGES)));

   // gain removal: constant multiply by the inverse CORDIC gain, rounded
   logic signed [PW-1:0] px;
   logic signed [PW-1:0] py;
   logic signed [PW-1:0] rx;
   logic signed [PW-1:0] ry;

   always_comb begin
      px = PW'(xc[STAGES]) * KIN;
      py = PW'(yc[STAGES]) * KIN;
      rx = (px + RND) >>> GAIN_FRAC;
      ry = (py + RND) >>> GAIN_FRAC;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_o <= '0;
         y_o <= '0;
      end else begin
         x_o <= DATA_W'(rx);
         y_o <= DATA_W'(ry);
      end
   end

   logic signed [IW-1:0] mag_xo;
   logic signed [IW-1:0] mag_yo;

   always_comb begin
      mag_xo = x_o[DATA_W-1] ? -IW'(x_o) : IW'(x_o);
      mag_yo = y_o[DATA_W-1] ? -IW'(y_o) : IW'(y_o);
   end

   // R5
   gain_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mag_xo <= $past(mag_xe)) && (mag_yo <= $past(mag_ye)));

endmodule

// File: rtl/tri_elim_array.sv
module tri_elim_array
   import tri_elim_pkg::*;
#(
   parameter int BLOCK     = 4,
   parameter int DATA_W    = 16,
   parameter int STAGES    = 14,
   parameter int GAIN_FRAC = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start_i,
   input  logic [BLOCK-1:0][DATA_W-1:0] piv_i,
   input  logic [BLOCK-1:0][DATA_W-1:0] tgt_i,
   output logic                         start_o,
   output logic [BLOCK-1:0][DATA_W-1:0] piv_o,
   output logic [BLOCK-1:0][DATA_W-1:0] tgt_o
);

   localparam int LAT    = unit_latency(STAGES);
   localparam int TOTAL  = BLOCK * LAT;
   localparam int NROT   = patch_count(BLOCK);
   localparam int WARM_W = $clog2(TOTAL + 1);

   if (BLOCK < 2 || BLOCK > 8) begin : g_bad_block
      $error("tri_elim_array: BLOCK must lie in 2..8");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("tri_elim_array: DATA_W must be at least 8");
   end
   if (NROT < BLOCK) begin : g_bad_count
      $error("tri_elim_array: rotor count inconsistent");
   end

   // start token delay line; tap k is the token k cycles after start
   logic [TOTAL-1:0] tok_sr;
   logic [TOTAL:0]   tok_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tok_sr <= '0;
      else        tok_sr <= {tok_sr[TOTAL-2:0], start_i};
   end

   assign tok_d   = {tok_sr, start_i};
   assign start_o = tok_d[TOTAL];

   // row streams between levels
   logic [DATA_W-1:0] pv [BLOCK+1][BLOCK];
   logic [DATA_W-1:0] tg [BLOCK+1][BLOCK];

   for (genvar r = 0; r < BLOCK; r++) begin : g_io
      assign pv[0][r] = piv_i[r];
      assign tg[0][r] = tgt_i[r];
      assign piv_o[r] = pv[BLOCK][r];
      assign tgt_o[r] = tg[BLOCK][r];
   end

   // diagonal wavefront: level l pairs pivot r with target r-l on column r
   for (genvar l = 0; l < BLOCK; l++) begin : g_lvl
      for (genvar r = 0; r < BLOCK; r++) begin : g_piv
         if (r >= l) begin : g_rot
            tri_elim_rotor #(
               .DATA_W   (DATA_W),
               .STAGES   (STAGES),
               .GAIN_FRAC(GAIN_FRAC)
            ) u_rot (
               .clk  (clk),
               .rst_n(rst_n),
               .tok_i(tok_d[level_tap(l, r, LAT)]),
               .x_i  (pv[l][r]),
               .y_i  (tg[l][r-l]),
               .x_o  (pv[l+1][r]),
               .y_o  (tg[l+1][r-l])
            );
         end else begin : g_pass
            tri_elim_delay #(
               .W    (DATA_W),
               .DEPTH(LAT)
            ) u_dly (
               .clk  (clk),
               .rst_n(rst_n),
               .d_i  (pv[l][r]),
               .d_o  (pv[l+1][r])
            );
         end
      end
      for (genvar j = 0; j < BLOCK; j++) begin : g_tgt
         if (j + l >= BLOCK) begin : g_pass
            tri_elim_delay #(
               .W    (DATA_W),
               .DEPTH(LAT)
            ) u_dly (
               .clk  (clk),
               .rst_n(rst_n),
               .d_i  (tg[l][j]),
               .d_o  (tg[l+1][j])
            );
         end
      end
   end

   // cycles since reset, saturating at the array latency
   logic [WARM_W-1:0] warm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   warm_q <= '0;
      else if (int'(warm_q) < TOTAL) warm_q <= warm_q + 1'b1;
   end

   // R1
   warm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> (int'(warm_q) == TOTAL));

   // R2
   start_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(start_o) |-> (int'(warm_q) >= TOTAL));

endmodule

// File: tb/sim_tri_elim_array.sv
module sim_tri_elim_array;

   localparam int  CLK_PERIOD = 10;
   localparam int  BLK        = 4;
   localparam int  DW         = 16;
   localparam int  STG        = 14;
   localparam int  COLS       = 3 * BLK;
   localparam int  NF         = 8;
   localparam int  NR         = 2 * BLK;
   localparam int  LAT_EXP    = BLK * (STG + 2);
   localparam real ONE        = 4096.0;
   localparam real TOL        = 0.02;

   logic                     clk = 1'b0;
   logic                     rst_n = 1'b0;
   logic                     start_i = 1'b0;
   logic [BLK-1:0][DW-1:0]   piv_i = '0;
   logic [BLK-1:0][DW-1:0]   tgt_i = '0;
   logic                     start_o;
   logic [BLK-1:0][DW-1:0]   piv_o;
   logic [BLK-1:0][DW-1:0]   tgt_o;

   tri_elim_array #(
      .BLOCK    (BLK),
      .DATA_W   (DW),
      .STAGES   (STG),
      .GAIN_FRAC(16)
   ) u0 (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start_i),
      .piv_i  (piv_i),
      .tgt_i  (tgt_i),
      .start_o(start_o),
      .piv_o  (piv_o),
      .tgt_o  (tgt_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int          checks = 0;
   int          failures = 0;
   int          cyc = 0;
   int          t_in = -1;
   int          t_out = -1;
   bit          done = 1'b0;
   int unsigned seed = 32'h1357_2468;

   int  fin  [NF][NR][COLS];
   real fout [NF][NR][COLS];

   always @(posedge clk) cyc <= cyc + 1;

   function automatic real to_r(input logic [DW-1:0] v);
      return $itor($signed(v)) / ONE;
   endfunction

   function automatic real absr(input real v);
      return (v < 0.0) ? -v : v;
   endfunction

   function int rnd(input int span);
      seed = seed * 32'd1103515245 + 32'd12345;
      return int'((seed >> 8) % (2 * span + 1)) - span;
   endfunction

   task automatic check(input string req, input bit ok, input real act, input real exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%f expected=%f", req, act, exp);
      end
   endtask

   // frame kinds: random, negative diagonals, zero targets, zero pivot diagonals, large
   task automatic gen_frame(input int f);
      int span;
      span = (f == 5 || f == 7) ? 3600 : 2800;
      for (int r = 0; r < NR; r++)
         for (int c = 0; c < COLS; c++) fin[f][r][c] = 0;
      for (int r = 0; r < BLK; r++) begin
         for (int c = r; c < BLK; c++) begin
            fin[f][r][c]       = rnd(span);
            fin[f][BLK + r][c] = rnd(span);
         end
         fin[f][r][BLK + r]           = int'(ONE);
         fin[f][BLK + r][2 * BLK + r] = int'(ONE);
      end
      if (f == 2) begin
         for (int r = 0; r < BLK; r++) begin
            fin[f][r][r]       = -((rnd(1500) + 1700));
            fin[f][BLK + r][r] = -((rnd(1000) + 1200));
         end
      end
      if (f == 3) begin
         for (int r = 0; r < BLK; r++) begin
            fin[f][r][r] = rnd(1000) + 1500;
            for (int c = 0; c < BLK; c++) fin[f][BLK + r][c] = 0;
         end
      end
      if (f == 4) begin
         for (int r = 0; r < BLK; r++) fin[f][r][r] = 0;
      end
      if (f == 7) begin
         for (int r = 0; r < BLK; r += 2) fin[f][r][r] = -3000;
      end
   endtask

   task automatic send_frame(input int f);
      for (int c = 0; c < COLS; c++) begin
         @(negedge clk);
         start_i = (c == 0);
         if (c == 0 && f == 0) t_in = cyc;
         for (int r = 0; r < BLK; r++) begin
            piv_i[r] = DW'(fin[f][r][c]);
            tgt_i[r] = DW'(fin[f][BLK + r][c]);
         end
      end
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         start_i = 1'b0;
         piv_i   = '0;
         tgt_i   = '0;
      end
   endtask

   // capture processed frames in order of arrival
   int cap_frame = 0;
   int cap_col   = -1;

   always @(negedge clk) begin
      if (rst_n && start_o) begin
         cap_col = 0;
         if (t_out < 0) t_out = cyc;
      end
      if (cap_col >= 0 && cap_frame < NF) begin
         for (int r = 0; r < BLK; r++) begin
            fout[cap_frame][r][cap_col]       = to_r(piv_o[r]);
            fout[cap_frame][BLK + r][cap_col] = to_r(tgt_o[r]);
         end
         cap_col++;
         if (cap_col == COLS) begin
            cap_frame++;
            cap_col = -1;
         end
      end
   end

   task automatic check_frame(input int f);
      real e_tgt, e_low, e_orth, e_cons, d_min, e_id, acc;
      e_tgt = 0.0; e_low = 0.0; e_orth = 0.0; e_cons = 0.0; d_min = 1.0e9; e_id = 0.0;
      for (int j = 0; j < BLK; j++)
         for (int c = 0; c < BLK; c++)
            if (absr(fout[f][BLK + j][c]) > e_tgt) e_tgt = absr(fout[f][BLK + j][c]);
      for (int i = 0; i < BLK; i++) begin
         for (int c = 0; c < i; c++)
            if (absr(fout[f][i][c]) > e_low) e_low = absr(fout[f][i][c]);
         if (fout[f][i][i] < d_min) d_min = fout[f][i][i];
      end
      for (int k = 0; k < NR; k++)
         for (int m = 0; m < NR; m++) begin
            acc = 0.0;
            for (int c = BLK; c < COLS; c++) acc += fout[f][k][c] * fout[f][m][c];
            acc -= (k == m) ? 1.0 : 0.0;
            if (absr(acc) > e_orth) e_orth = absr(acc);
         end
      for (int k = 0; k < NR; k++)
         for (int c = 0; c < BLK; c++) begin
            acc = 0.0;
            for (int m = 0; m < NR; m++) acc += fout[f][k][BLK + m] * ($itor(fin[f][m][c]) / ONE);
            if (absr(acc - fout[f][k][c]) > e_cons) e_cons = absr(acc - fout[f][k][c]);
         end
      // R3 target patch cleared
      check($sformatf("R3 frame %0d max target entry", f), e_tgt <= TOL, e_tgt, 0.0);
      // R4 pivot rows stay triangular
      check($sformatf("R4 frame %0d max pivot sub-diagonal", f), e_low <= TOL, e_low, 0.0);
      // R5 appended part orthonormal (R8 for the back-to-back frames)
      check($sformatf("R5 R8 frame %0d max |G*G'-I|", f), e_orth <= TOL, e_orth, 0.0);
      // R6 same transform on every column
      check($sformatf("R6 frame %0d max |out-G*A|", f), e_cons <= TOL, e_cons, 0.0);
      // R7 pivot diagonals non-negative
      check($sformatf("R7 frame %0d min pivot diagonal", f), d_min >= -TOL, d_min, 0.0);
      if (f == 3) begin
         for (int k = 0; k < NR; k++)
            for (int c = 0; c < COLS; c++)
               if (absr(fout[f][k][c] - $itor(fin[f][k][c]) / ONE) > e_id)
                  e_id = absr(fout[f][k][c] - $itor(fin[f][k][c]) / ONE);
         // R9 zero targets leave rows unchanged
         check("R9 frame 3 max |out-in|", e_id <= TOL, e_id, 0.0);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      for (int f = 0; f < NF; f++) gen_frame(f);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 start_o after reset", start_o == 1'b0, $itor(start_o), 0.0);
      check("R1 piv_o after reset", piv_o == '0, $itor(piv_o[0]), 0.0);
      check("R1 tgt_o after reset", tgt_o == '0, $itor(tgt_o[0]), 0.0);
      // R8 four frames with no gap, then four with gaps
      for (int f = 0; f < 4; f++) send_frame(f);
      idle(7);
      for (int f = 4; f < NF; f++) begin
         send_frame(f);
         idle(5);
      end
      wait (cap_frame == NF);
      @(negedge clk);
      // R2 latency
      check("R2 start_i to start_o cycles", (t_out - t_in) == LAT_EXP,
            $itor(t_out - t_in), $itor(LAT_EXP));
      for (int f = 0; f < NF; f++) check_frame(f);
      done = 1'b1;
      finish_run();
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d frames", cap_frame, NF);
         finish_run();
      end
   end

endmodule